// File: doc/BRIEF.md
# Set/Clear Peripheral Register Front End

This block is the register front end that sits between a 32-bit peripheral bus and the function logic of one peripheral. It holds a command strobe register, a plain read/write configuration register, a status bit group, and an interrupt mask bit group. The status and mask groups are never written directly. Each group has one address that sets bits and another that clears bits, using write-one semantics. Software can therefore change any subset of bits with a single bus write, with no read-modify-write sequence that an interrupt could split.

The peripheral's function logic receives one-cycle command pulses and the current mode word. It raises status bits through single-cycle event pulses. A single interrupt request is formed as the OR over all status bits qualified by their mask bits. The bus bridge and the address decoding above the block supply a select, a write flag, a byte address and the write data. Read data is returned combinationally from the current register state.

The block has no sequencing state of its own. Every register updates on the clock edge at which its write is presented.

Top module: `setclr_regs`

## Requirements
- R1: Only full words are addressed. The two lowest address bits are ignored for both reads and writes, so byte address 0x07 reaches the same register as 0x04.
- R2: A write to offset 0x00 (command) drives `cmd_pulse` with the low CMD_W data bits for exactly the one cycle after the write edge. Zero bits produce no pulse, and `cmd_pulse` is zero in every other cycle.
- R3: Offset 0x04 holds a MODE_W-bit mode word that can be read and written. It resets to 0, and written data bits above MODE_W are discarded.
- R4: A write to 0x10 sets every status bit whose data bit is 1, and a write to 0x14 clears every status bit whose data bit is 1. Zero data bits leave status unchanged. Status reads back at 0x18, and reading it changes nothing.
- R5: A 1 on bit i of `evt_set` during a cycle sets status bit i at that clock edge.
- R6: When a status bit is cleared through 0x14 at the same edge as it is set (by an event or a set write), the clear wins and the bit ends 0.
- R7: The interrupt mask resets to 0. A write of ones to 0x20 sets mask bits, a write of ones to 0x24 clears them, and the mask reads back at 0x28.
- R8: `irq` is high exactly when some bit is 1 in both status and mask. It follows register state without further delay.
- R9: Register bits above each implemented width read as 0. Reads of the write-only offsets (0x00, 0x10, 0x14, 0x20, 0x24) and of any unmapped offset return 0.
- R10: After reset, status, mask and mode are 0, `cmd_pulse` is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Block is addressed this cycle |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from state |
| cmd_pulse | output | CMD_W | One-cycle command strobes |
| mode_q | output | MODE_W | Current mode word |
| evt_set | input | STAT_W | Hardware pulses that set status bits |
| status_q | output | STAT_W | Current status bits |
| irq | output | 1 | Interrupt request |

## Verification
The status and mask groups are driven with the following patterns:
- Mixed set and clear words, which separate write-one-to-set from plain overwrite.
- All-zero writes, which expose any zero bit that has an effect.
- Event pulses on bits that software has never touched.
- A clear write landing on the same edge as an event on the same bit, which fixes the priority rule.

Mode and command writes use wide data words and unaligned addresses, which show the truncation and the address folding. Reads of the write-only and unmapped offsets confirm that they return zero. `irq` is compared every cycle against a behavioural model while the mask is built up bit by bit, which tells a correct AND-OR gating apart from ungated or inverted forms.

// File: rtl/spr_pkg.sv
package spr_pkg;
    // Word index (byte offset >> 2) for each register
    localparam int IDX_CMD  = 0;
    localparam int IDX_MODE = 1;
    localparam int IDX_SSET = 4;
    localparam int IDX_SCLR = 5;
    localparam int IDX_STAT = 6;
    localparam int IDX_MSET = 8;
    localparam int IDX_MCLR = 9;
    localparam int IDX_MASK = 10;
    localparam int BUS_W    = 32;
endpackage

// File: rtl/spr_cmd_strobe.sv
module spr_cmd_strobe #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] bits,
    output logic [W-1:0] pulse
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulse <= '0;
        else if (fire)
            pulse <= bits;
        else
            pulse <= '0;
    end

    // R2
    pulse_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |-> $past(fire));
endmodule

// File: rtl/spr_setclr_bank.sv
module spr_setclr_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    logic [W-1:0] q_next;

    // Clear has priority over set for every bit
    always_comb begin
        q_next = (q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_next;
    end

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((q & $past(clr_i)) == '0));
    // R4
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q & $past(set_i) & ~$past(clr_i)) == ($past(set_i) & ~$past(clr_i))));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(q));
endmodule

// File: rtl/spr_read_mux.sv
module spr_read_mux
    import spr_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int MODE_W = 12,
    parameter int STAT_W = 10
) (
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [MODE_W-1:0] mode,
    input  logic [STAT_W-1:0] stat,
    input  logic [STAT_W-1:0] mask,
    output logic [BUS_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (int'(word_idx) == IDX_MODE)
            rdata = BUS_W'(mode);
        else if (int'(word_idx) == IDX_STAT)
            rdata = BUS_W'(stat);
        else if (int'(word_idx) == IDX_MASK)
            rdata = BUS_W'(mask);
    end
endmodule

// File: rtl/setclr_regs.sv
module setclr_regs
    import spr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CMD_W  = 8,
    parameter int MODE_W = 12,
    parameter int STAT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [CMD_W-1:0]  cmd_pulse,
    output logic [MODE_W-1:0] mode_q,
    input  logic [STAT_W-1:0] evt_set,
    output logic [STAT_W-1:0] status_q,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    logic              wr_en;
    logic              wr_cmd, wr_mode, wr_sset, wr_sclr, wr_mset, wr_mclr;
    logic [STAT_W-1:0] stat_set, stat_clr, mask_set, mask_clr;
    logic [STAT_W-1:0] mask_q;
    logic              unused_bits;

    assign word_idx    = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};
    assign wr_en       = bus_sel & bus_wr;

    always_comb begin
        wr_cmd  = wr_en && (int'(word_idx) == IDX_CMD);
        wr_mode = wr_en && (int'(word_idx) == IDX_MODE);
        wr_sset = wr_en && (int'(word_idx) == IDX_SSET);
        wr_sclr = wr_en && (int'(word_idx) == IDX_SCLR);
        wr_mset = wr_en && (int'(word_idx) == IDX_MSET);
        wr_mclr = wr_en && (int'(word_idx) == IDX_MCLR);
        stat_set = (wr_sset ? bus_wdata[STAT_W-1:0] : '0) | evt_set;
        stat_clr =  wr_sclr ? bus_wdata[STAT_W-1:0] : '0;
        mask_set =  wr_mset ? bus_wdata[STAT_W-1:0] : '0;
        mask_clr =  wr_mclr ? bus_wdata[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= bus_wdata[MODE_W-1:0];
    end

    spr_cmd_strobe #(.W(CMD_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .fire(wr_cmd),
        .bits(bus_wdata[CMD_W-1:0]), .pulse(cmd_pulse)
    );

    spr_setclr_bank #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(stat_set), .clr_i(stat_clr), .q(status_q)
    );

    spr_setclr_bank #(.W(STAT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_i(mask_set), .clr_i(mask_clr), .q(mask_q)
    );

    spr_read_mux #(.IDX_W(IDX_W), .MODE_W(MODE_W), .STAT_W(STAT_W)) u_rd (
        .word_idx(word_idx), .mode(mode_q), .stat(status_q), .mask(mask_q), .rdata(bus_rdata)
    );

    assign irq = |(status_q & mask_q);

    // R8
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));
    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_q));
endmodule

// File: tb/tb_setclr_regs.sv
module tb_setclr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cmd_pulse;
    logic [11:0] mode_q;
    logic [9:0]  evt_set = '0;
    logic [9:0]  status_q;
    logic        irq;

    int checks = 0, failures = 0;

    // Behavioural reference state
    logic [7:0]  m_cmd = '0;
    logic [11:0] m_mode = '0;
    logic [9:0]  m_stat = '0, m_mask = '0;

    always #10 clk = ~clk;

    setclr_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_pulse(cmd_pulse), .mode_q(mode_q), .evt_set(evt_set),
        .status_q(status_q), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Model advances on every edge and is compared just after it
    always begin
        logic [7:0]  n_cmd;
        logic [11:0] n_mode;
        logic [9:0]  n_stat, n_mask;
        int          widx;
        logic        wr;
        @(posedge clk);
        widx = int'(bus_addr) / 4;
        wr   = bus_sel && bus_wr;
        if (!rst_n) begin
            n_cmd = '0; n_mode = '0; n_stat = '0; n_mask = '0;
        end else begin
            n_cmd  = (wr && widx == 0) ? bus_wdata[7:0] : 8'h00;
            n_mode = (wr && widx == 1) ? bus_wdata[11:0] : m_mode;
            for (int i = 0; i < 10; i++) begin
                logic s, k;
                s = m_stat[i];
                k = m_mask[i];
                if (wr && widx == 4 && bus_wdata[i]) s = 1'b1;
                if (evt_set[i]) s = 1'b1;
                if (wr && widx == 5 && bus_wdata[i]) s = 1'b0;
                if (wr && widx == 8 && bus_wdata[i]) k = 1'b1;
                if (wr && widx == 9 && bus_wdata[i]) k = 1'b0;
                n_stat[i] = s;
                n_mask[i] = k;
            end
        end
        #1;
        m_cmd = n_cmd; m_mode = n_mode; m_stat = n_stat; m_mask = n_mask;
        check("R2 cmd_pulse", 32'(cmd_pulse), 32'(m_cmd));
        check("R3 mode_q", 32'(mode_q), 32'(m_mode));
        check("R4/R5/R6 status_q", 32'(status_q), 32'(m_stat));
        check("R8 irq", 32'(irq), 32'(|(m_stat & m_mask)));
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [9:0] ev);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_set = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; evt_set = '0;
    endtask

    task automatic pulse_evt(input logic [9:0] ev);
        @(negedge clk);
        evt_set = ev;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        bus_read(8'h18, 32'h0, "R10 status after reset");
        bus_read(8'h28, 32'h0, "R10 mask after reset");
        bus_read(8'h04, 32'h0, "R10 mode after reset");
        // R3, R9 mode truncation
        bus_write(8'h04, 32'hFFFF_FFFF, '0);
        bus_read(8'h04, 32'h0000_0FFF, "R3 R9 mode wide write");
        // R1 unaligned addresses
        bus_write(8'h07, 32'h0000_0ABC, '0);
        bus_read(8'h05, 32'h0000_0ABC, "R1 mode unaligned");
        bus_write(8'h03, 32'h0000_00A5, '0);   // R2 command via unaligned address
        bus_read(8'h00, 32'h0, "R9 command reads zero");
        // R4 set/clear
        bus_write(8'h10, 32'hFFFF_00F3, '0);
        bus_read(8'h18, 32'h0000_00F3, "R4 set write");
        bus_write(8'h14, 32'h0000_0021, '0);
        bus_read(8'h18, 32'h0000_00D2, "R4 clear write");
        bus_write(8'h10, 32'h0, '0);
        bus_read(8'h18, 32'h0000_00D2, "R4 zero write no effect");
        bus_read(8'h18, 32'h0000_00D2, "R4 read no side effect");
        // R5 events
        pulse_evt(10'h300);
        bus_read(8'h18, 32'h0000_03D2, "R5 event sets status");
        // R7 mask and R8 irq
        bus_write(8'h20, 32'h0000_0001, '0);
        bus_read(8'h28, 32'h0000_0001, "R7 mask set");
        bus_write(8'h20, 32'h0000_0002, '0);
        bus_read(8'h28, 32'h0000_0003, "R7 mask accumulate");
        #2 check("R8 irq high", 32'(irq), 32'h1);
        // R9 write-only and unmapped
        bus_read(8'h20, 32'h0, "R9 mask-set reads zero");
        bus_read(8'h24, 32'h0, "R9 mask-clear reads zero");
        bus_read(8'h14, 32'h0, "R9 status-clear reads zero");
        bus_read(8'h10, 32'h0, "R9 status-set reads zero");
        bus_read(8'h3C, 32'h0, "R9 unmapped reads zero");
        bus_read(8'h0C, 32'h0, "R9 gap reads zero");
        // R6 clear beats simultaneous event
        bus_write(8'h14, 32'h0000_0002, 10'h102);
        bus_read(8'h18, 32'h0000_03D0, "R6 clear wins over event");
        #2 check("R8 irq low after clear", 32'(irq), 32'h0);
        bus_write(8'h24, 32'h0000_0003, '0);
        bus_read(8'h28, 32'h0, "R7 mask clear");
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule